// File: doc/BRIEF.md
# Pipelined Synchronous SRAM with Byte-Lane Writes

This block is a single-port synchronous memory built from four 9-bit byte lanes, each made of eight data bits and one parity bit. Address, chip selects, strobes, write enables and write data are all captured on the rising clock edge. Read data passes through a second register, so a word whose address is captured on one edge appears after the following edge. An address generator outside the block supplies every address, so the block keeps no burst sequence of its own. Cycles that carry no strobe continue at the address already held, either reading it again or writing it.

A cycle opens on either of two strobes. The controller strobe always opens a cycle, and its write decision is taken on that same edge. The processor strobe counts only while the active-low chip enable is low. When it opens a cycle, the write inputs are ignored on that edge, and the write decision moves to the next edge. The output is not a tri-state pin. It is modelled by a data bus and a separate valid flag. The flag drops at once when output enable goes high, when any write is requested on the inputs, or during sleep. A high sleep input freezes every register and the storage. The contents are kept, and the user deselects the block on the first cycle after sleep ends.

Top module: `pl_ssram`

## Requirements
- R1: A cycle opens when `strobe_ctrl_n` is low, or when `strobe_proc_n` and `chip_en_n` are both low. The block is selected only if, on that edge, `chip_en_n` is low, `chip_sel_hi` is high and `chip_sel_lo_n` is low. Any other opening is a deselect. It starts no read, and `rd_valid` is low for the cycles it governs.
- R2: A read opened on edge N presents its word after edge N+1 and not before. Cycles without a strobe that follow a selected cycle read the held address again.
- R3: With `wr_all_n` low on a cycle where writes are sampled, all four lanes are written, whatever `lane_wen_n` and `lane_sel_n` hold.
- R4: With `wr_all_n` high and `lane_wen_n` low, exactly the lanes k with `lane_sel_n[k]` low are written. Several lanes may be written in one cycle.
- R5: With `wr_all_n` and `lane_wen_n` both high, the cycle is a read, and `lane_sel_n` has no effect on storage.
- R6: Lane k holds `wr_data[8k+7:8k]` and parity bit `wr_par[k]`, and returns them on `rd_data[8k+7:8k]` and `rd_par[k]`.
- R7: On an edge where the processor strobe opens a cycle, the write inputs are ignored, even if the controller strobe is also low. They are sampled on the next edge that carries no strobe, and that write goes to the captured address. A cycle opened by the controller strobe writes on its own edge.
- R8: While `chip_en_n` is high, a low `strobe_proc_n` opens no cycle. The held address and the selection are kept.
- R9: `rd_valid` is low whenever `out_en_n` is high. It is also low whenever the inputs request a write: `wr_all_n` low, or `lane_wen_n` low with any `lane_sel_n` bit low. Both act in the same cycle without a clock edge. `rd_data` and `rd_par` are zero whenever `rd_valid` is low.
- R10: While `sleep` is high, no register or storage word changes and `rd_valid` is low. Stored words survive sleep.
- R11: After reset the block is deselected and `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the control state |
| sleep | input | 1 | High freezes the block and keeps its contents |
| chip_en_n | input | 1 | Active-low chip enable; also qualifies the processor strobe |
| chip_sel_hi | input | 1 | Active-high chip select |
| chip_sel_lo_n | input | 1 | Active-low chip select |
| strobe_proc_n | input | 1 | Processor address strobe, active low, deferred write decision |
| strobe_ctrl_n | input | 1 | Controller address strobe, active low |
| addr | input | AW | Word address captured when a cycle opens |
| wr_all_n | input | 1 | Active-low global write of all lanes |
| lane_wen_n | input | 1 | Active-low enable that passes the lane selects through |
| lane_sel_n | input | LANES | Active-low per-lane write selects |
| wr_data | input | LANES*LANE_DW | Write data, lane k in bits 8k..8k+7 |
| wr_par | input | LANES | Write parity, bit k for lane k |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| rd_data | output | LANES*LANE_DW | Registered read data, zero when not valid |
| rd_par | output | LANES | Registered read parity, zero when not valid |
| rd_valid | output | 1 | High when the read bus would be driven |

## Verification
The hardest case to reach is the deferred write behind the processor strobe. On the opening edge the write inputs must be active and must be ignored, and on the next edge, with no strobe, they must take effect at the captured address. The stimulus first stores a known word and then opens a processor-strobe cycle with the global write low. In one run it follows with an idle continuation, and in another with a write continuation carrying different data. A later read of the same address tells the two outcomes apart. Sleep is reached in the same way: a write is attempted while frozen, and after wake-up and a deselect a fresh read shows the old word still in place.

// File: rtl/pl_ssram_pkg.sv
package pl_ssram_pkg;

   // Kind of cycle decided on a clock edge
   typedef enum logic [1:0] {
      CYC_CONT = 2'd0,   // no strobe: continue at held address
      CYC_OPEN = 2'd1,   // strobe with a valid select: new selected cycle
      CYC_DROP = 2'd2    // strobe without a valid select: deselect
   } cyc_kind_e;

   // Raw lane write request from the write-enable pins (active-low inputs)
   function automatic logic lane_request(input logic all_n, input logic en_n,
                                         input logic sel_n);
      return (!all_n) || (!en_n && !sel_n);
   endfunction

endpackage

// File: rtl/pl_ssram_ctl.sv
module pl_ssram_ctl
   import pl_ssram_pkg::*;
#(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          chip_en_n,
   input  logic          chip_sel_hi,
   input  logic          chip_sel_lo_n,
   input  logic          strobe_proc_n,
   input  logic          strobe_ctrl_n,
   input  logic [AW-1:0] addr,
   input  logic          any_we,
   output logic          proc_go,
   output cyc_kind_e     kind,
   output logic          acc_sel,
   output logic [AW-1:0] acc_addr,
   output logic [AW-1:0] cur_addr,
   output logic          rd_pend
);

   logic sel_q;
   logic opens;
   logic chip_ok;

   always_comb begin
      proc_go = !strobe_proc_n && !chip_en_n;
      opens   = proc_go || !strobe_ctrl_n;
      chip_ok = !chip_en_n && chip_sel_hi && !chip_sel_lo_n;
      if (!opens)       kind = CYC_CONT;
      else if (chip_ok) kind = CYC_OPEN;
      else              kind = CYC_DROP;
      unique case (kind)
         CYC_OPEN: begin acc_sel = 1'b1;  acc_addr = addr;     end
         CYC_DROP: begin acc_sel = 1'b0;  acc_addr = addr;     end
         default:  begin acc_sel = sel_q; acc_addr = cur_addr; end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q    <= 1'b0;
         cur_addr <= '0;
         rd_pend  <= 1'b0;
      end else if (run) begin
         sel_q    <= acc_sel;
         cur_addr <= acc_addr;
         rd_pend  <= acc_sel && !any_we;
      end
   end

endmodule

// File: rtl/pl_ssram_wdec.sv
module pl_ssram_wdec
   import pl_ssram_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic             wr_all_n,
   input  logic             lane_wen_n,
   input  logic [LANES-1:0] lane_sel_n,
   input  logic             hold_off,
   output logic [LANES-1:0] lane_req,
   output logic [LANES-1:0] lane_we,
   output logic             req_any
);

   for (genvar k = 0; k < LANES; k++) begin : g_dec
      assign lane_req[k] = lane_request(wr_all_n, lane_wen_n, lane_sel_n[k]);
      assign lane_we[k]  = lane_req[k] && !hold_off;
   end

   assign req_any = |lane_req;

endmodule

// File: rtl/pl_ssram_lane.sv
module pl_ssram_lane #(
   parameter int DEPTH = 256,
   parameter int LW    = 9,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          run,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [LW-1:0] wd,
   input  logic [AW-1:0] raddr,
   output logic [LW-1:0] q
);

   logic [LW-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (run) begin
         if (we) store[waddr] <= wd;
         q <= store[raddr];
      end
   end

endmodule

// File: rtl/pl_ssram.sv
module pl_ssram
   import pl_ssram_pkg::*;
#(
   parameter int DEPTH   = 256,
   parameter int LANES   = 4,
   parameter int LANE_DW = 8,
   localparam int AW     = $clog2(DEPTH),
   localparam int DW     = LANES * LANE_DW,
   localparam int LW     = LANE_DW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sleep,
   input  logic             chip_en_n,
   input  logic             chip_sel_hi,
   input  logic             chip_sel_lo_n,
   input  logic             strobe_proc_n,
   input  logic             strobe_ctrl_n,
   input  logic [AW-1:0]    addr,
   input  logic             wr_all_n,
   input  logic             lane_wen_n,
   input  logic [LANES-1:0] lane_sel_n,
   input  logic [DW-1:0]    wr_data,
   input  logic [LANES-1:0] wr_par,
   input  logic             out_en_n,
   output logic [DW-1:0]    rd_data,
   output logic [LANES-1:0] rd_par,
   output logic             rd_valid
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("pl_ssram: DEPTH must be a power of two of at least 2");
   end
   if (LANES < 1 || LANE_DW < 1) begin : g_bad_lane
      $error("pl_ssram: LANES and LANE_DW must be positive");
   end

   logic             run;
   logic             proc_go;
   cyc_kind_e        kind;
   logic             acc_sel;
   logic [AW-1:0]    acc_addr;
   logic [AW-1:0]    cur_addr;
   logic             rd_pend;
   logic [LANES-1:0] lane_req;
   logic [LANES-1:0] lane_we;
   logic             req_any;
   logic             vld_q;
   logic             drive;

   assign run = !sleep;

   pl_ssram_wdec #(.LANES(LANES)) u_wdec (
      .wr_all_n   (wr_all_n),
      .lane_wen_n (lane_wen_n),
      .lane_sel_n (lane_sel_n),
      .hold_off   (proc_go),
      .lane_req   (lane_req),
      .lane_we    (lane_we),
      .req_any    (req_any)
   );

   pl_ssram_ctl #(.AW(AW)) u_ctl (
      .clk           (clk),
      .rst_n         (rst_n),
      .run           (run),
      .chip_en_n     (chip_en_n),
      .chip_sel_hi   (chip_sel_hi),
      .chip_sel_lo_n (chip_sel_lo_n),
      .strobe_proc_n (strobe_proc_n),
      .strobe_ctrl_n (strobe_ctrl_n),
      .addr          (addr),
      .any_we        (|lane_we),
      .proc_go       (proc_go),
      .kind          (kind),
      .acc_sel       (acc_sel),
      .acc_addr      (acc_addr),
      .cur_addr      (cur_addr),
      .rd_pend       (rd_pend)
   );

   // Output stage valid flag: second pipeline register
   always_ff @(posedge clk) begin
      if (!rst_n)   vld_q <= 1'b0;
      else if (run) vld_q <= rd_pend;
   end

   assign drive    = vld_q && !out_en_n && !sleep && !req_any;
   assign rd_valid = drive;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [LW-1:0] q_k;
      pl_ssram_lane #(.DEPTH(DEPTH), .LW(LW)) u_lane (
         .clk   (clk),
         .run   (run),
         .we    (lane_we[k] && acc_sel && run),
         .waddr (acc_addr),
         .wd    ({wr_par[k], wr_data[k*LANE_DW +: LANE_DW]}),
         .raddr (cur_addr),
         .q     (q_k)
      );
      assign rd_data[k*LANE_DW +: LANE_DW] = drive ? q_k[LANE_DW-1:0] : '0;
      assign rd_par[k]                     = drive ? q_k[LANE_DW]     : 1'b0;
   end

endmodule

// File: rtl/pl_ssram_chk.sv
module pl_ssram_chk #(
   parameter int AW      = 8,
   parameter int LANES   = 4,
   parameter int LANE_DW = 8
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     sleep,
   input logic                     out_en_n,
   input logic                     wr_all_n,
   input logic                     strobe_ctrl_n,
   input logic                     rd_valid,
   input logic [LANES*LANE_DW-1:0] rd_data,
   input logic [LANES-1:0]         rd_par,
   input logic                     proc_go,
   input logic [1:0]               kind,
   input logic                     rd_pend,
   input logic                     vld_q,
   input logic [AW-1:0]            cur_addr,
   input logic [LANES-1:0]         lane_we
);

   AST_OE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
      out_en_n |-> !rd_valid);                                      // R9
   AST_WRQ_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_all_n |-> !rd_valid);                                     // R9
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> (rd_data == '0 && rd_par == '0));               // R9
   AST_SLEEP_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !rd_valid);                                         // R10
   AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> ($stable(cur_addr) && $stable(vld_q)));             // R10
   AST_PROC_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
      proc_go |-> (lane_we == '0));                                 // R7
   AST_DROP_NOREAD: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && kind == 2'd2) |=> !rd_pend);                       // R1
   AST_GLOBAL_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (!proc_go && !wr_all_n) |-> (&lane_we));                      // R3
   AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && !proc_go && strobe_ctrl_n) |=> $stable(cur_addr)); // R8

endmodule

bind pl_ssram pl_ssram_chk #(.AW(AW), .LANES(LANES), .LANE_DW(LANE_DW)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .sleep         (sleep),
   .out_en_n      (out_en_n),
   .wr_all_n      (wr_all_n),
   .strobe_ctrl_n (strobe_ctrl_n),
   .rd_valid      (rd_valid),
   .rd_data       (rd_data),
   .rd_par        (rd_par),
   .proc_go       (proc_go),
   .kind          (kind),
   .rd_pend       (rd_pend),
   .vld_q         (vld_q),
   .cur_addr      (cur_addr),
   .lane_we       (lane_we)
);

// File: tb/pl_ssram_bench.sv
module pl_ssram_bench;

   localparam int DEPTH = 256;
   localparam int AW    = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sleep = 1'b0;
   logic        chip_en_n = 1'b1;
   logic        chip_sel_hi = 1'b1;
   logic        chip_sel_lo_n = 1'b0;
   logic        strobe_proc_n = 1'b1;
   logic        strobe_ctrl_n = 1'b1;
   logic [7:0]  addr = '0;
   logic        wr_all_n = 1'b1;
   logic        lane_wen_n = 1'b1;
   logic [3:0]  lane_sel_n = 4'hF;
   logic [31:0] wr_data = '0;
   logic [3:0]  wr_par = '0;
   logic        out_en_n = 1'b0;
   logic [31:0] rd_data;
   logic [3:0]  rd_par;
   logic        rd_valid;

   int n_chk = 0;
   int n_err = 0;

   always #10 clk = ~clk;

   pl_ssram #(.DEPTH(DEPTH)) u_pl_ssram (
      .clk(clk), .rst_n(rst_n), .sleep(sleep), .chip_en_n(chip_en_n),
      .chip_sel_hi(chip_sel_hi), .chip_sel_lo_n(chip_sel_lo_n),
      .strobe_proc_n(strobe_proc_n), .strobe_ctrl_n(strobe_ctrl_n),
      .addr(addr), .wr_all_n(wr_all_n), .lane_wen_n(lane_wen_n),
      .lane_sel_n(lane_sel_n), .wr_data(wr_data), .wr_par(wr_par),
      .out_en_n(out_en_n), .rd_data(rd_data), .rd_par(rd_par),
      .rd_valid(rd_valid)
   );

   // ---------------- behavioural reference ----------------
   logic [35:0] bmem [int];
   logic        m_sel = 1'b0, m_pend = 1'b0, m_vld = 1'b0;
   int          m_addr = 0;
   logic [35:0] m_q = 'x;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_sel = 1'b0; m_pend = 1'b0; m_vld = 1'b0;
      end else if (!sleep) begin
         bit          pgo, opens, ok, asel;
         int          aa;
         logic [3:0]  ln;
         logic [35:0] w;
         m_vld = m_pend;
         m_q   = bmem.exists(m_addr) ? bmem[m_addr] : 'x;
         pgo   = !strobe_proc_n && !chip_en_n;
         opens = pgo || !strobe_ctrl_n;
         ok    = !chip_en_n && chip_sel_hi && !chip_sel_lo_n;
         asel  = opens ? ok : m_sel;
         aa    = opens ? int'(addr) : m_addr;
         if (pgo)              ln = 4'h0;
         else if (!wr_all_n)   ln = 4'hF;
         else if (!lane_wen_n) ln = ~lane_sel_n;
         else                  ln = 4'h0;
         if (asel && ln != 0) begin
            w = bmem.exists(aa) ? bmem[aa] : 'x;
            for (int k = 0; k < 4; k++)
               if (ln[k]) begin
                  w[8*k +: 8] = wr_data[8*k +: 8];
                  w[32+k]     = wr_par[k];
               end
            bmem[aa] = w;
         end
         m_pend = asel && (ln == 0);
         m_sel  = asel;
         m_addr = aa;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // settle, compare against the model for the current inputs
   task automatic look();
      bit e_v, wreq;
      #2;
      wreq = !wr_all_n || (!lane_wen_n && lane_sel_n != 4'hF);
      e_v  = m_vld && !out_en_n && !sleep && !wreq && rst_n;
      chk(rd_valid == e_v, "R9 model valid", 64'(rd_valid), 64'(e_v));
      if (!e_v)
         chk(rd_data == 0 && rd_par == 0, "R9 idle bus zero",
             {28'd0, rd_par, rd_data}, 64'd0);
      else if (!$isunknown(m_q))
         chk({rd_par, rd_data} == m_q, "R2 R6 model data",
             {28'd0, rd_par, rd_data}, {28'd0, m_q});
   endtask

   task automatic nxt();
      @(negedge clk);
   endtask

   task automatic idle();
      strobe_proc_n = 1'b1; strobe_ctrl_n = 1'b1; chip_en_n = 1'b0;
      chip_sel_hi = 1'b1; chip_sel_lo_n = 1'b0;
      wr_all_n = 1'b1; lane_wen_n = 1'b1; lane_sel_n = 4'hF;
   endtask

   task automatic desel();
      idle(); strobe_ctrl_n = 1'b0; chip_en_n = 1'b1;
      look(); nxt();
   endtask

   task automatic wr_ctrl(input logic [7:0] a, input bit all, input logic [3:0] lsn,
                          input logic [31:0] d, input logic [3:0] p);
      idle(); strobe_ctrl_n = 1'b0; addr = a;
      wr_all_n = !all; lane_wen_n = 1'b0; lane_sel_n = lsn;
      wr_data = d; wr_par = p;
      look(); nxt();
      desel();
   endtask

   // deselect, open a read, check latency, return the word
   task automatic rd_word(input logic [7:0] a, input string req,
                          input logic [35:0] exp);
      desel();
      idle(); strobe_ctrl_n = 1'b0; addr = a;
      look(); nxt();
      idle();
      look();
      chk(rd_valid == 1'b0, "R2 not yet valid one edge after opening",
          64'(rd_valid), 64'd0);
      nxt();
      idle();
      look();
      chk(rd_valid && {rd_par, rd_data} == exp, req,
          {27'd0, rd_valid, rd_par, rd_data}, {27'd0, 1'b1, exp});
      nxt();
      desel();
   endtask

   task automatic run_tests();
      repeat (3) nxt();
      look();
      chk(rd_valid == 1'b0, "R11 reset leaves output invalid", 64'(rd_valid), 64'd0);
      rst_n = 1'b1;
      desel();

      // R3: global write overrides lane selects
      wr_ctrl(8'd5, 1'b1, 4'hF, 32'h11223344, 4'b1010);
      rd_word(8'd5, "R3 R6 global write, lane data and parity", 36'hA_11223344);

      // R4: lanes 0 and 2 written together
      wr_ctrl(8'd5, 1'b0, 4'b1010, 32'hAABBCCDD, 4'b0101);
      rd_word(8'd5, "R4 two-lane byte write merge", 36'hF_11BB33DD);

      // R5: lane selects ignored without lane enable
      idle(); strobe_ctrl_n = 1'b0; addr = 8'd5; lane_sel_n = 4'h0;
      wr_data = 32'hFFFFFFFF; wr_par = 4'h0;
      look(); nxt();
      rd_word(8'd5, "R5 lane selects without enable leave word", 36'hF_11BB33DD);

      // R7 (a): processor start ignores write inputs on its edge
      wr_ctrl(8'd9, 1'b1, 4'hF, 32'h55555555, 4'b0011);
      idle(); strobe_proc_n = 1'b0; addr = 8'd9; wr_all_n = 1'b0;
      wr_data = 32'hDEADBEEF; wr_par = 4'hF;
      look();
      chk(rd_valid == 1'b0, "R9 write request drops valid", 64'(rd_valid), 64'd0);
      nxt();
      idle(); look(); nxt();
      rd_word(8'd9, "R7 processor strobe edge did not write", 36'h3_55555555);

      // R7 (b): deferred write lands on the next edge
      idle(); strobe_proc_n = 1'b0; addr = 8'd9; wr_all_n = 1'b0;
      wr_data = 32'hDEADBEEF; wr_par = 4'hF;
      look(); nxt();
      idle(); wr_all_n = 1'b0; wr_data = 32'h01020304; wr_par = 4'h4;
      look(); nxt();
      rd_word(8'd9, "R7 deferred write at captured address", 36'h4_01020304);

      // R8: processor strobe with chip enable high opens nothing
      desel();
      idle(); strobe_ctrl_n = 1'b0; addr = 8'd5; look(); nxt();
      idle(); chip_en_n = 1'b1; strobe_proc_n = 1'b0; addr = 8'd9; look(); nxt();
      idle(); look(); nxt();
      idle(); look();
      chk(rd_valid && rd_data == 32'h11BB33DD, "R8 address held while enable high",
          {31'd0, rd_valid, rd_data}, {31'd0, 1'b1, 32'h11BB33DD});
      // R2: continuation keeps rereading; R9: output enable is asynchronous
      out_en_n = 1'b1; #1;
      chk(rd_valid == 1'b0, "R9 output enable high floats", 64'(rd_valid), 64'd0);
      out_en_n = 1'b0; #1;
      chk(rd_valid == 1'b1, "R9 output enable low drives again", 64'(rd_valid), 64'd1);
      look(); nxt();

      // R10: sleep freezes and keeps contents
      sleep = 1'b1;
      idle(); look();
      chk(rd_valid == 1'b0, "R10 output invalid while asleep", 64'(rd_valid), 64'd0);
      nxt();
      idle(); strobe_ctrl_n = 1'b0; addr = 8'd5; wr_all_n = 1'b0; wr_data = 32'h0;
      wr_par = 4'h0; look(); nxt();
      idle(); look(); nxt();
      sleep = 1'b0;
      desel();
      rd_word(8'd5, "R10 word retained across sleep", 36'hF_11BB33DD);

      // R1: bad chip selects give a deselect
      idle(); strobe_ctrl_n = 1'b0; addr = 8'd5; chip_sel_hi = 1'b0;
      look(); nxt();
      idle(); look(); nxt();
      idle(); look();
      chk(rd_valid == 1'b0, "R1 select-high low deselects", 64'(rd_valid), 64'd0);
      nxt();
      idle(); strobe_ctrl_n = 1'b0; addr = 8'd5; chip_sel_lo_n = 1'b1;
      look(); nxt();
      idle(); look(); nxt();
      idle(); look();
      chk(rd_valid == 1'b0, "R1 select-low high deselects", 64'(rd_valid), 64'd0);
      nxt();
      // R1 write on a deselect is dropped
      idle(); strobe_ctrl_n = 1'b0; addr = 8'd5; chip_en_n = 1'b1; wr_all_n = 1'b0;
      wr_data = 32'h0; wr_par = 4'h0; look(); nxt();
      rd_word(8'd5, "R1 deselected write dropped", 36'hF_11BB33DD);
   endtask

   initial begin
      bit timed_out = 1'b0;
      @(negedge clk);
      fork
         run_tests();
         begin
            repeat (200000) @(posedge clk);
            timed_out = 1'b1;
         end
      join_any
      disable fork;
      if (timed_out) chk(1'b0, "watchdog expired", 64'd1, 64'd0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule